// File: doc/BRIEF.md
# Program Counter and Subroutine Stack Unit

This unit holds the 15-bit instruction address of a small 8-bit controller. It treats the address as a 7-bit upper part and an 8-bit lower part. One operation is accepted per cycle while the unit is idle. Each operation either moves the address in a single cycle (step, jumps, indirect jump through a program-ROM byte) or runs a short sequence on a byte-wide data-memory port to save or restore a return address.

Saved addresses are kept in data memory under an 8-bit stack pointer. The stack grows toward lower addresses by two bytes per entry. The low address byte goes at the pointer and the upper seven bits go one byte below it. Returns undo this, and the interrupt-return form also sets the global interrupt enable. Interrupt entry saves the address and forces a fixed vector. Instruction decode and arithmetic are handled elsewhere: the unit only sees an operation code, an argument field, the accumulator value and the ROM byte.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pc` is 0, `sp` is SP_RESET (0x6F by default), `gie` is 0 and `busy` is 0.
- R2: Code 0 (step) sets `pc` to `pc`+1, wrapping from 0x7FFF to 0, and never raises `busy`.
- R3: Code 1 (long jump) loads all 15 bits of `op_arg` into `pc`.
- R4: Code 2 (short jump) replaces `pc[11:0]` with `op_arg[11:0]` and keeps `pc[14:12]`.
- R5: Code 3 (relative jump) reads `op_arg[7:0]` as a signed offset r. If r lies in -31..+32 and is not +1, `pc` becomes `pc`+r; any other r advances `pc` by 1.
- R6: Code 9 (indirect jump) drives `rom_addr` = {`pc[14:8]`, `acc`} and replaces `pc[7:0]` with `rom_data`. The upper seven bits are kept.
- R7: Code 4 (long call, target `op_arg`) and code 5 (short call, target formed as in R4) save `pc`+1. The first busy cycle writes its low byte at address `sp`. The second writes {0, upper 7 bits} at `sp`-1. `sp` then drops by 2 and `pc` takes the target, with `busy` high for exactly 2 cycles.
- R8: Code 6 (return) reads the low byte from `sp`+2 and then the upper 7 bits (bits 6:0 of the byte) from `sp`+1. It then loads `pc` from them and raises `sp` by 2, with `busy` high for exactly 3 cycles. Data memory returns `mem_rdata` one cycle after `mem_re`.
- R9: Code 7 (interrupt return) behaves as R8 and also sets `gie` to 1.
- R10: Code 8 (interrupt entry) saves the current `pc` (not `pc`+1) with the sequence of R7, then loads `pc` with 0x0FF; `gie` is cleared.
- R11: `op_valid` is ignored while `busy` is high; memory is only accessed while `busy` is high, and never with `mem_we` and `mem_re` together.
- R12: Codes 10 to 15 leave `pc`, `sp` and `gie` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request, taken when `busy` is low |
| op_code | input | 4 | Operation code (see requirements) |
| op_arg | input | 15 | Jump/call target; low 8 bits are the signed relative offset |
| acc | input | 8 | Accumulator value for the indirect jump |
| rom_addr | output | 15 | Program ROM address for the indirect jump |
| rom_data | input | 8 | Program ROM byte at `rom_addr`, same cycle |
| mem_addr | output | 8 | Data memory address for stack accesses |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write byte |
| mem_re | output | 1 | Data memory read strobe |
| mem_rdata | input | 8 | Data memory read byte, one cycle after `mem_re` |
| pc | output | 15 | Current program counter |
| sp | output | 8 | Current stack pointer |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | High while a stack sequence is running |

## Verification
A wrong sequencer state shows at once as a bad strobe pattern: a write without its partner at the pointer minus one, a read overlapping a write, or a busy window that is one cycle too long or short. A corrupted saved byte or a wrong stack-pointer step stays hidden until the matching return. It then appears as a wrong `pc` in the cycle `busy` falls, so every call in the bench is paired with a return and the restored address is compared. Next-address faults in the single-cycle paths show in `pc` one cycle after the request.

// File: rtl/pcsu_pkg.sv
package pcsu_pkg;
    localparam int PC_W    = 15;
    localparam int LO_W    = 8;
    localparam int HI_W    = PC_W - LO_W;
    localparam int SHORT_W = 12;
    localparam int SP_W    = 8;
    localparam int OFS_W   = 8;

    typedef logic [PC_W-1:0] pc_t;
    typedef logic [SP_W-1:0] sp_t;

    typedef enum logic [3:0] {
        OP_STEP   = 4'd0,
        OP_JLONG  = 4'd1,
        OP_JSHORT = 4'd2,
        OP_JREL   = 4'd3,
        OP_CLONG  = 4'd4,
        OP_CSHORT = 4'd5,
        OP_RET    = 4'd6,
        OP_RETI   = 4'd7,
        OP_IRQ    = 4'd8,
        OP_JIND   = 4'd9
    } pc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_FIN
    } seq_e;

    typedef struct packed {
        pc_t  next_pc;
        pc_t  target;
        pc_t  ret_pc;
        logic stack_op;
    } pc_plan_t;

    function automatic logic rel_ok(input logic signed [OFS_W-1:0] r,
                                    input int lo, input int hi);
        return (int'(r) >= lo) && (int'(r) <= hi) && (int'(r) != 1);
    endfunction
endpackage

// File: rtl/pcsu_next.sv
module pcsu_next
    import pcsu_pkg::*;
#(
    parameter int  REL_MIN = -31,
    parameter int  REL_MAX = 32,
    parameter pc_t IRQ_VEC = 15'h00FF
) (
    input  pc_op_e           op,
    input  pc_t              pc,
    input  pc_t              arg,
    input  logic [LO_W-1:0]  rom_byte,
    output pc_plan_t         plan
);
    pc_t inc_pc;
    pc_t short_pc;
    pc_t rel_pc;
    pc_t ind_pc;
    logic rel_legal;

    assign inc_pc    = pc + PC_W'(1);
    assign short_pc  = {pc[PC_W-1:SHORT_W], arg[SHORT_W-1:0]};
    assign rel_pc    = pc + {{(PC_W-OFS_W){arg[OFS_W-1]}}, arg[OFS_W-1:0]};
    assign ind_pc    = {pc[PC_W-1:LO_W], rom_byte};
    assign rel_legal = rel_ok(arg[OFS_W-1:0], REL_MIN, REL_MAX);

    always_comb begin
        plan.next_pc  = pc;
        plan.target   = pc;
        plan.ret_pc   = inc_pc;
        plan.stack_op = 1'b0;
        case (op)
            OP_STEP:   plan.next_pc = inc_pc;
            OP_JLONG:  plan.next_pc = arg;
            OP_JSHORT: plan.next_pc = short_pc;
            OP_JREL:   plan.next_pc = rel_legal ? rel_pc : inc_pc;
            OP_JIND:   plan.next_pc = ind_pc;
            OP_CLONG: begin
                plan.target   = arg;
                plan.stack_op = 1'b1;
            end
            OP_CSHORT: begin
                plan.target   = short_pc;
                plan.stack_op = 1'b1;
            end
            OP_IRQ: begin
                plan.target   = IRQ_VEC;
                plan.ret_pc   = pc;
                plan.stack_op = 1'b1;
            end
            OP_RET, OP_RETI: plan.stack_op = 1'b1;
            default: plan.next_pc = pc;
        endcase
    end
endmodule

// File: rtl/pcsu_stack.sv
module pcsu_stack
    import pcsu_pkg::*;
#(
    parameter sp_t SP_RESET = 8'h6F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  pc_op_e          op,
    input  pc_t             ret_pc,
    input  pc_t             tgt_pc,
    output sp_t             mem_addr,
    output logic            mem_we,
    output logic [LO_W-1:0] mem_wdata,
    output logic            mem_re,
    input  logic [LO_W-1:0] mem_rdata,
    output sp_t             sp,
    output logic            gie,
    output logic            busy,
    output logic            pc_load,
    output pc_t             pc_val
);
    seq_e            st;
    pc_t             ret_q;
    pc_t             tgt_q;
    logic            reti_q;
    logic [LO_W-1:0] lo_q;
    logic            rdata_unused;

    assign rdata_unused = ^mem_rdata[LO_W-1:HI_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sp     <= SP_RESET;
            gie    <= 1'b0;
            ret_q  <= '0;
            tgt_q  <= '0;
            reti_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    ret_q  <= ret_pc;
                    tgt_q  <= tgt_pc;
                    reti_q <= (op == OP_RETI);
                    case (op)
                        OP_CLONG, OP_CSHORT: st <= ST_PUSH_LO;
                        OP_IRQ: begin
                            st  <= ST_PUSH_LO;
                            gie <= 1'b0;
                        end
                        OP_RET, OP_RETI: st <= ST_POP_LO;
                        default: st <= ST_IDLE;
                    endcase
                end
                ST_PUSH_LO: st <= ST_PUSH_HI;
                ST_PUSH_HI: begin
                    sp <= sp - SP_W'(2);
                    st <= ST_IDLE;
                end
                ST_POP_LO: st <= ST_POP_HI;
                ST_POP_HI: begin
                    lo_q <= mem_rdata;
                    st   <= ST_POP_FIN;
                end
                ST_POP_FIN: begin
                    sp <= sp + SP_W'(2);
                    if (reti_q) gie <= 1'b1;
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp;
        mem_wdata = ret_q[LO_W-1:0];
        case (st)
            ST_PUSH_LO: mem_we = 1'b1;
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp - SP_W'(1);
                mem_wdata = LO_W'(ret_q[PC_W-1:LO_W]);
            end
            ST_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = sp + SP_W'(2);
            end
            ST_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp + SP_W'(1);
            end
            default: ;
        endcase
    end

    assign busy    = (st != ST_IDLE);
    assign pc_load = (st == ST_PUSH_HI) || (st == ST_POP_FIN);
    assign pc_val  = (st == ST_PUSH_HI) ? tgt_q : {mem_rdata[HI_W-1:0], lo_q};
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
    import pcsu_pkg::*;
#(
    parameter logic [7:0]  SP_RESET = 8'h6F,
    parameter int          REL_MIN  = -31,
    parameter int          REL_MAX  = 32,
    parameter logic [14:0] IRQ_VEC  = 15'h00FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [14:0] op_arg,
    input  logic [7:0]  acc,
    output logic [14:0] rom_addr,
    input  logic [7:0]  rom_data,
    output logic [7:0]  mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic [14:0] pc,
    output logic [7:0]  sp,
    output logic        gie,
    output logic        busy
);
    pc_op_e   op_e;
    pc_plan_t plan;
    logic     accept;
    logic     stk_load;
    pc_t      stk_pc;

    assign op_e     = pc_op_e'(op_code);
    assign accept   = op_valid && !busy;
    assign rom_addr = {pc[PC_W-1:LO_W], acc};

    pcsu_next #(
        .REL_MIN (REL_MIN),
        .REL_MAX (REL_MAX),
        .IRQ_VEC (IRQ_VEC)
    ) u_next (
        .op       (op_e),
        .pc       (pc),
        .arg      (op_arg),
        .rom_byte (rom_data),
        .plan     (plan)
    );

    pcsu_stack #(
        .SP_RESET (SP_RESET)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && plan.stack_op),
        .op        (op_e),
        .ret_pc    (plan.ret_pc),
        .tgt_pc    (plan.target),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata),
        .sp        (sp),
        .gie       (gie),
        .busy      (busy),
        .pc_load   (stk_load),
        .pc_val    (stk_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (stk_load) begin
            pc <= stk_pc;
        end else if (accept && !plan.stack_op) begin
            pc <= plan.next_pc;
        end
    end
endmodule

// File: rtl/pcsu_checker.sv
module pcsu_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [14:0] op_arg,
    input logic [14:0] pc,
    input logic [7:0]  sp,
    input logic        gie,
    input logic        busy,
    input logic        mem_we,
    input logic        mem_re,
    input logic [7:0]  mem_addr
);
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code == 4'd0) |=> (pc == $past(pc) + 15'd1));

    p_long_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code == 4'd1) |=> (pc == $past(op_arg)));

    p_rel_plus_one_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code == 4'd3 && op_arg[7:0] == 8'd1)
        |=> (pc == $past(pc) + 15'd1));

    p_push_pair_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) - 8'd1));

    p_sp_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp) |-> (sp == $past(sp) + 8'd2 || sp == $past(sp) - 8'd2));

    p_irq_gie_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_code == 4'd8) |=> !gie);

    p_port_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, mem_re}));

    p_mem_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);
endmodule

bind pc_stack_unit pcsu_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_arg   (op_arg),
    .pc       (pc),
    .sp       (sp),
    .gie      (gie),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr)
);

// File: tb/tb_pc_stack_unit.sv
`timescale 1ns/1ps
module tb_pc_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [14:0] op_arg = '0;
    logic [7:0]  acc = '0;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_re;
    logic [7:0]  mem_rdata = '0;
    logic [14:0] pc;
    logic [7:0]  sp;
    logic        gie;
    logic        busy;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] smem [256];

    always #5 clk = ~clk;

    function automatic logic [7:0] romf(input logic [14:0] a);
        return a[7:0] * 8'd5 + {1'b0, a[14:8]} + 8'h3C;
    endfunction
    assign rom_data = romf(rom_addr);

    always @(posedge clk) begin
        if (mem_we) smem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= smem[mem_addr];
    end

    pc_stack_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_arg(op_arg), .acc(acc), .rom_addr(rom_addr), .rom_data(rom_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .pc(pc), .sp(sp),
        .gie(gie), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] code, input logic [14:0] arg,
                         input logic [7:0] a, output int bcyc);
        @(negedge clk);
        op_code  = code;
        op_arg   = arg;
        acc      = a;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        bcyc = 0;
        while (busy) begin
            bcyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int bc;
        logic [14:0] e;
        logic [7:0]  s0;
        logic [14:0] rets [8];
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", 32'(pc), 32'h0);
        chk("R1 sp in reset", 32'(sp), 32'h6F);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pc", 32'(pc), 32'h0);
        chk("R1 sp", 32'(sp), 32'h6F);
        chk("R1 gie", 32'(gie), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);

        // R2: stepping and wrap
        for (int i = 1; i <= 20; i++) begin
            issue(4'd0, '0, '0, bc);
            chk("R2 step pc", 32'(pc), 32'(i));
            chk("R2 step no busy", 32'(bc), 32'h0);
        end
        issue(4'd1, 15'h7FFF, '0, bc);
        issue(4'd0, '0, '0, bc);
        chk("R2 wrap", 32'(pc), 32'h0);

        // R3: long jumps
        for (int i = 0; i < 16; i++) begin
            e = 15'(i * 32'h0923 + 32'h0111);
            issue(4'd1, e, '0, bc);
            chk("R3 long jump", 32'(pc), 32'(e));
        end

        // R4: short jumps keep pc[14:12]
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 6; i++) begin
                logic [14:0] base, arg;
                base = (b == 0) ? 15'h5123 : (b == 1) ? 15'h7FFF : 15'h0000;
                arg  = 15'(i * 32'h1357 + 32'h0ABC);
                issue(4'd1, base, '0, bc);
                issue(4'd2, arg, '0, bc);
                e = {base[14:12], arg[11:0]};
                chk("R4 short jump", 32'(pc), 32'(e));
            end
        end

        // R5: relative offsets around the legal window
        for (int r = -40; r <= 40; r++) begin
            issue(4'd1, 15'h2000, '0, bc);
            issue(4'd3, 15'(r & 8'hFF), '0, bc);
            if (r >= -31 && r <= 32 && r != 1) e = 15'(32'h2000 + r);
            else e = 15'h2001;
            chk("R5 relative", 32'(pc), 32'(e));
        end

        // R6: indirect jump through ROM byte
        issue(4'd1, 15'h3A55, '0, bc);
        for (int a = 0; a < 256; a += 17) begin
            e = {7'h3A, romf({7'h3A, 8'(a)})};
            issue(4'd9, '0, 8'(a), bc);
            chk("R6 indirect", 32'(pc), 32'(e));
        end

        // R7: long call
        issue(4'd1, 15'h1234, '0, bc);
        issue(4'd4, 15'h4567, '0, bc);
        chk("R7 call busy cycles", 32'(bc), 32'd2);
        chk("R7 call pc", 32'(pc), 32'h4567);
        chk("R7 call sp", 32'(sp), 32'h6D);
        chk("R7 low byte at sp", 32'(smem[8'h6F]), 32'h35);
        chk("R7 upper at sp-1", 32'(smem[8'h6E]), 32'h12);
        // R7: short call
        issue(4'd5, 15'h0ABC, '0, bc);
        chk("R7 short call pc", 32'(pc), 32'h4ABC);
        chk("R7 short call sp", 32'(sp), 32'h6B);
        chk("R7 short low", 32'(smem[8'h6D]), 32'h68);
        chk("R7 short upper", 32'(smem[8'h6C]), 32'h45);

        // R10: interrupt entry
        issue(4'd8, '0, '0, bc);
        chk("R10 irq pc", 32'(pc), 32'h00FF);
        chk("R10 irq sp", 32'(sp), 32'h69);
        chk("R10 irq low", 32'(smem[8'h6B]), 32'hBC);
        chk("R10 irq upper", 32'(smem[8'h6A]), 32'h4A);
        chk("R10 irq gie", 32'(gie), 32'h0);

        // R9: interrupt return
        issue(4'd7, '0, '0, bc);
        chk("R9 reti pc", 32'(pc), 32'h4ABC);
        chk("R9 reti sp", 32'(sp), 32'h6B);
        chk("R9 reti gie", 32'(gie), 32'h1);
        chk("R9 reti busy", 32'(bc), 32'd3);

        // R8: plain returns
        issue(4'd6, '0, '0, bc);
        chk("R8 ret pc", 32'(pc), 32'h4568);
        chk("R8 ret sp", 32'(sp), 32'h6D);
        chk("R8 ret busy", 32'(bc), 32'd3);
        issue(4'd6, '0, '0, bc);
        chk("R8 ret pc outer", 32'(pc), 32'h1235);
        chk("R8 ret sp outer", 32'(sp), 32'h6F);
        chk("R9 ret keeps gie", 32'(gie), 32'h1);

        // R10: entry clears an enabled gie, R9 restores it
        issue(4'd8, '0, '0, bc);
        chk("R10 gie cleared", 32'(gie), 32'h0);
        issue(4'd7, '0, '0, bc);
        chk("R9 gie set", 32'(gie), 32'h1);
        chk("R9 back to caller", 32'(pc), 32'h1235);

        // R7/R8: nested calls and unwinding
        s0 = sp;
        for (int d = 0; d < 8; d++) begin
            logic [14:0] t;
            rets[d] = pc + 15'd1;
            t = 15'(d * 32'h0E11 + 32'h1FF0);
            issue(4'd4, t, '0, bc);
            chk("R7 nested pc", 32'(pc), 32'(t));
            chk("R7 nested sp", 32'(sp), 32'(8'(s0 - 8'(2 * (d + 1)))));
        end
        for (int d = 7; d >= 0; d--) begin
            issue(4'd6, '0, '0, bc);
            chk("R8 nested pc", 32'(pc), 32'(rets[d]));
        end
        chk("R8 nested sp", 32'(sp), 32'(s0));

        // R11: requests while busy are ignored
        issue(4'd1, 15'h0100, '0, bc);
        @(negedge clk);
        op_code = 4'd4; op_arg = 15'h2222; op_valid = 1'b1;
        @(negedge clk);
        op_code = 4'd1; op_arg = 15'h0777;
        chk("R11 busy during call", 32'(busy), 32'h1);
        @(negedge clk);
        chk("R11 busy second cycle", 32'(busy), 32'h1);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R11 pc ignores busy request", 32'(pc), 32'h2222);
        chk("R11 sp after call", 32'(sp), 32'(8'(s0 - 8'd2)));
        issue(4'd6, '0, '0, bc);
        chk("R11 return after ignored op", 32'(pc), 32'h0101);

        // R12: unused codes
        for (int c = 10; c < 16; c++) begin
            issue(4'(c), 15'h5555, 8'hAA, bc);
            chk("R12 pc unchanged", 32'(pc), 32'h0101);
            chk("R12 sp unchanged", 32'(sp), 32'(s0));
            chk("R12 gie unchanged", 32'(gie), 32'h1);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule